// File: doc/BRIEF.md
# Power-Latched Binary Interval Timer

The block measures one interval whose length is a power of two of a slow tick. A start request turns the hold output on and clears an internal counter. While hold is on, each tick-enable cycle advances the counter. The interval ends when the selected counter bit first becomes set, which happens after exactly 2^n ticks. At that point hold turns off, a one-cycle done pulse is emitted, and the block waits for the next start.

The hold output can drive an external power or relay latch. In that use, the timed circuit keeps itself powered until the interval runs out. An abort request ends the interval at any time and gives no done pulse. The exponent n comes from a tap-select field and is captured when the interval starts.

Top module: `pwr_latch_timer`

## Requirements
- R1: After reset, hold and done are both 0.
- R2: When the block is idle and start is 1 with abort 0 at a clock edge, hold is 1 after that edge and the tick count restarts from zero.
- R3: Once set, hold stays 1 after start returns to 0. The count advances only on cycles where tick is 1.
- R4: With captured exponent n, hold falls at the clock edge that takes the 2^n-th tick of the interval.
- R5: A normal end gives done = 1 for exactly the one cycle after hold falls. done is 0 at all other times.
- R6: abort = 1 while hold is 1 clears hold at the next edge and gives no done pulse. This holds even when the same cycle carries the final tick.
- R7: A start while hold is 1 is ignored. The count is not restarted and the end time does not move.
- R8: tap_sel is sampled only when the interval starts. Later changes to it do not change the end time.
- R9: A tap_sel value of 0 is treated as n = 1, so the interval is 2 ticks.
- R10: When the block is idle and start and abort are both 1, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable from the slow oscillator |
| start | input | 1 | Begin an interval when idle |
| abort | input | 1 | End the interval immediately, with no done pulse |
| tap_sel | input | SEL_W | Exponent n of the interval length 2^n; 0 is treated as 1 |
| hold | output | 1 | Active / power-hold output |
| done | output | 1 | One-cycle pulse on a normal end |

## Verification
The bench builds the timer with CNT_W = 8, which makes SEL_W = 3. At that size every tap from 1 up to the top one (128 ticks) can run to completion in a short run. That includes the highest counter bit, so an indexing error at the top of the counter becomes visible. Short taps are driven with dense ticks and with sparse ticks. A restart during an interval, a tap change during an interval, and an abort on the final tick are each compared with a behavioural tick-count model on every cycle.

// File: rtl/pwr_latch_timer.sv
module pwr_latch_timer #(
  parameter int CNT_W = 32,
  parameter int SEL_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             abort,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             hold,
  output logic             done
);

  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] tap;
  logic [CNT_W-1:0] cnt_nxt;
  logic             expire;

  assign cnt_nxt = cnt + 1'b1;
  assign expire  = tick && cnt_nxt[tap];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      tap  <= SEL_W'(1);
    end else begin
      done <= 1'b0;
      if (!hold) begin
        if (start && !abort) begin
          hold <= 1'b1;
          cnt  <= '0;
          tap  <= (tap_sel == '0) ? SEL_W'(1) : tap_sel;
        end
      end else if (abort) begin
        hold <= 1'b0;
      end else if (expire) begin
        hold <= 1'b0;
        done <= 1'b1;
      end else if (tick) begin
        cnt <= cnt_nxt;
      end
    end
  end

  a_r2_start_sets_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hold && start && !abort |=> hold);
  a_r3_idle_tick_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !tick && !abort |=> hold);
  a_r5_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hold && $past(hold));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold && abort |=> !hold && !done);
  a_r10_idle_abort_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !hold && abort |=> !hold);

endmodule

// File: tb/tb_pwr_latch_timer.sv
module tb_pwr_latch_timer;
  localparam int CW = 8;
  localparam int SW = $clog2(CW);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0, abort = 1'b0;
  logic [SW-1:0] tap_sel = '0;
  logic hold, done;

  int n_cmp = 0, n_bad = 0;
  bit m_act = 0, m_done = 0;
  int m_cnt = 0, m_n = 1;
  string tag = "R1";

  always #10 clk = ~clk;

  pwr_latch_timer #(.CNT_W(CW)) dut (.clk(clk), .rst_n(rst_n), .tick(tick),
    .start(start), .abort(abort), .tap_sel(tap_sel), .hold(hold), .done(done));

  task automatic compare();
    n_cmp++;
    if (hold !== m_act || done !== m_done) begin
      n_bad++;
      $display("FAIL %s t=%0t hold=%b done=%b expected hold=%b done=%b",
               tag, $time, hold, done, m_act, m_done);
    end
  endtask

  // drive one cycle, predict post-edge state, compare after the edge
  task automatic cyc(input bit t, input bit s, input bit a, input int sel);
    bit was;
    tick = t; start = s; abort = a; tap_sel = SW'(sel);
    was = m_act;
    m_done = 0;
    if (!was) begin
      if (s && !a) begin m_act = 1; m_cnt = 0; m_n = (sel == 0) ? 1 : sel; end
    end else if (a) begin
      m_act = 0;
    end else if (t) begin
      m_cnt++;
      if (m_cnt == (1 << m_n)) begin m_act = 0; m_done = 1; end
    end
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  task automatic run_ticks(input int k, input int gap, input int sel);
    for (int i = 0; i < k; i++) begin
      cyc(1, 0, 0, sel);
      for (int g = 0; g < gap; g++) cyc(0, 0, 0, sel);
    end
  endtask

  initial begin
    #3_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired hold=%b done=%b expected finish", hold, done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);

    tag = "R2_R4_R5 dense n=2";
    cyc(0, 1, 0, 2);
    run_ticks(5, 0, 2);
    cyc(0, 0, 0, 0);

    tag = "R3_R4 sparse n=3";
    cyc(0, 1, 0, 3);
    run_ticks(9, 2, 0);

    tag = "R9 sel0";
    cyc(0, 1, 0, 0);
    run_ticks(3, 1, 0);

    tag = "R7 restart ignored";
    cyc(0, 1, 0, 2);
    run_ticks(2, 0, 2);
    cyc(1, 1, 0, 2);
    cyc(0, 1, 0, 2);
    run_ticks(3, 0, 2);

    tag = "R8 tap captured";
    cyc(0, 1, 0, 1);
    run_ticks(1, 0, 6);
    run_ticks(2, 0, 6);

    tag = "R6 abort mid";
    cyc(0, 1, 0, 3);
    run_ticks(3, 0, 3);
    cyc(0, 0, 1, 3);
    cyc(0, 0, 0, 3);

    tag = "R6 abort on last tick";
    cyc(0, 1, 0, 1);
    cyc(1, 0, 0, 1);
    cyc(1, 0, 1, 1);
    cyc(0, 0, 0, 1);

    tag = "R10 start+abort idle";
    cyc(0, 1, 1, 2);
    cyc(1, 0, 0, 2);

    tag = "R4 top tap n=7";
    cyc(0, 1, 0, 7);
    run_ticks(130, 0, 0);

    tag = "R2 back-to-back";
    cyc(0, 1, 0, 1);
    run_ticks(2, 0, 1);
    cyc(0, 1, 0, 1);
    run_ticks(3, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule